// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog counter on a small 16-bit register bus, clocked from a slow timebase. Software picks a timeout in half-second steps and switches the counter on. From then on it must prove it is alive. To do so it writes a two-word key to the service register before the count runs out. If the key does not arrive in time, the block raises a system reset request and records the cause. In an alternative mode it emits a one-cycle expiry pulse and restarts the count instead.

Once the counter is enabled, software cannot stop it. The low-power suspend choice can be made only once after each reset. Software can also ask for a reset on purpose. It does this with two control writes that have the active-low request bit cleared, and both writes must land within a short window of slow-clock cycles. The cause register sits on a separate power-on reset. It therefore survives the reset that the block itself requested.

Bus accesses are single-cycle. A write is taken on the clock edge where `busSel` and `busWr` are both high. Read data is combinational whenever `busSel` is high and `busWr` is low, and is zero otherwise.

Top module: `keyed_watchdog`

## Requirements
- R1: After power-on reset, the control register (offset 0x0) reads 0x0010, the cause register (offset 0x4) reads 0x0000, and both `sysRstReq` and `expiryPulse` are low.
- R2: Control bits 15:8 hold a step count W. Once loaded, the counter expires after exactly (W+1)*STEP_CYCLES running clock edges. No expiry can happen while the enable bit is 0.
- R3: Control bit 2 is the enable. Writing 1 sets it. A later write of 0 leaves it at 1, and only a reset clears it.
- R4: Control bit 0 is the suspend bit. The first control write after reset fixes its value, and later writes leave it unchanged. While it is 1 and `lowPower` is high, the countdown is paused.
- R5: Control bit 3 selects the action on expiry. With 0, `sysRstReq` rises and stays high until reset. With 1, `expiryPulse` is high for exactly one cycle and the count restarts from W.
- R6: A write of 0x5555 to the service register (offset 0x2), followed by a write of 0xAAAA, reloads the counter. Any other value written between them cancels the sequence, while a repeated 0x5555 keeps it armed. A 0xAAAA that is not armed has no effect.
- R7: The cause register reports bit 1 for a timeout reset and bit 0 for a software reset. It is captured when a request is first raised, ignores bus writes, survives `rstN`, and is cleared only by `porN`.
- R8: Rewriting W while the counter runs does not change the current countdown. The new W is used at the next reload.
- R9: Control bit 4 is the active-low software reset request. Two control writes with bit 4 at 0, no more than SRS_WIN cycles apart, raise `sysRstReq`. A single such write, or two writes further apart, do not.
- R10: The write that first sets the enable bit loads the counter with the W carried in that same write.
- R11: A read of offset 0x0 returns {W, 3'b0, bit4, bit3, bit2, 1'b0, bit0}. A read of 0x2 returns 0, and a read of 0x4 returns the cause bits in 1:0. With `busSel` low, the read data is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow timebase clock |
| porN | input | 1 | Power-on reset, active low; clears everything, including the cause register |
| rstN | input | 1 | System reset, active low; clears all but the cause register |
| busSel | input | 1 | Register access select |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, combinational |
| lowPower | input | 1 | System low-power state, pauses the count when the suspend bit is set |
| sysRstReq | output | 1 | System reset request, held until reset |
| expiryPulse | output | 1 | One-cycle expiry event in no-reset mode |

## Verification
On every cycle, the assertions check the following: the reset request holds once raised, the expiry pulse never lasts two cycles, the enable bit never falls, the suspend bit is frozen once locked, no pulse appears while disabled, and the cause bits stay put while a request is pending. Other behaviour can only be shown by the bench's scenarios against its cycle model. This covers the exact expiry cycle for each step count, a cancelled key versus a completed one, the deferred effect of a rewritten step count, the pause under low power, and the window rule for the two software-reset writes.

// File: rtl/kwd_pkg.sv
`timescale 1ns/1ps
package kwd_pkg;
  localparam int REG_W   = 16;
  localparam int WT_W    = 8;
  localparam int WT_LSB  = 8;
  localparam int BIT_SUSP = 0;
  localparam int BIT_EN   = 2;
  localparam int BIT_MODE = 3;
  localparam int BIT_SWRN = 4;
  localparam int ST_SW    = 0;
  localparam int ST_EXP   = 1;
  localparam int ST_W     = 2;

  localparam logic [2:0] OFF_CTRL = 3'h0;
  localparam logic [2:0] OFF_SVC  = 3'h2;
  localparam logic [2:0] OFF_STAT = 3'h4;

  localparam logic [REG_W-1:0] KEY_ARM  = 16'h5555;
  localparam logic [REG_W-1:0] KEY_FIRE = 16'hAAAA;

  typedef enum logic {
    KEY_IDLE  = 1'b0,
    KEY_ARMED = 1'b1
  } keyState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic            load;        // restart countdown from loadVal
    logic [WT_W-1:0] loadVal;     // step count for any (re)load
    logic            run;         // countdown may advance this cycle
    logic            modeNoReset; // expiry pulses instead of requesting reset
    logic            swReq;       // software reset request qualified
  } strobe_t;
endpackage

// File: rtl/kwd_keyseq.sv
`timescale 1ns/1ps
module kwd_keyseq
  import kwd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             svcWr,
  input  logic [REG_W-1:0] wdata,
  output logic             reloadHit
);
  keyState_e keyState;

  assign reloadHit = svcWr && (keyState == KEY_ARMED) && (wdata == KEY_FIRE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyState <= KEY_IDLE;
    end else if (svcWr) begin
      // first word (re)arms; anything else, including the fire word, disarms
      keyState <= (wdata == KEY_ARM) ? KEY_ARMED : KEY_IDLE;
    end
  end
endmodule

// File: rtl/kwd_srs_detect.sv
`timescale 1ns/1ps
module kwd_srs_detect #(
  parameter int SRS_WIN = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lowWr,
  output logic swHit
);
  logic armed;

  assign swHit = lowWr && armed;

  generate
    if (SRS_WIN == 1) begin : g_adjacent
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) armed <= 1'b0;
        else       armed <= lowWr && !armed;
      end
    end else begin : g_window
      localparam int AGE_W = $clog2(SRS_WIN);
      logic [AGE_W-1:0] age;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          armed <= 1'b0;
          age   <= '0;
        end else if (lowWr) begin
          armed <= !armed;
          age   <= '0;
        end else if (armed) begin
          if (age == AGE_W'(SRS_WIN - 1)) armed <= 1'b0;
          else                            age   <= age + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/kwd_ctrl.sv
`timescale 1ns/1ps
module kwd_ctrl
  import kwd_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int SRS_WIN = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  input  logic              lowPower,
  input  logic [ST_W-1:0]   status,
  output strobe_t           strobe,
  output logic              wdeQ,
  output logic              wdzQ,
  output logic              wdzLockQ
);
  logic [WT_W-1:0] wtQ;
  logic            wreQ;
  logic            srsNQ;

  logic hitCtrl, hitSvc, hitStat;
  logic ctrlWr, svcWr, isRead;
  logic enableRise, reloadHit, lowWr, swHit;
  logic [REG_W-1:0] ctrlImage;
  logic [REG_W-1:0] statImage;

  assign hitCtrl = (busAddr == ADDR_W'(OFF_CTRL));
  assign hitSvc  = (busAddr == ADDR_W'(OFF_SVC));
  assign hitStat = (busAddr == ADDR_W'(OFF_STAT));
  assign ctrlWr  = busSel && busWr && hitCtrl;
  assign svcWr   = busSel && busWr && hitSvc;
  assign isRead  = busSel && !busWr;

  assign enableRise = ctrlWr && busWdata[BIT_EN] && !wdeQ;
  assign lowWr      = ctrlWr && !busWdata[BIT_SWRN];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wtQ      <= '0;
      wreQ     <= 1'b0;
      wdeQ     <= 1'b0;
      srsNQ    <= 1'b1;
      wdzQ     <= 1'b0;
      wdzLockQ <= 1'b0;
    end else if (ctrlWr) begin
      wtQ   <= busWdata[WT_LSB +: WT_W];
      wreQ  <= busWdata[BIT_MODE];
      wdeQ  <= wdeQ | busWdata[BIT_EN];
      srsNQ <= busWdata[BIT_SWRN];
      if (!wdzLockQ) begin
        wdzQ     <= busWdata[BIT_SUSP];
        wdzLockQ <= 1'b1;
      end
    end
  end

  kwd_keyseq u_key (
    .clk      (clk),
    .rstN     (rstN),
    .svcWr    (svcWr),
    .wdata    (busWdata),
    .reloadHit(reloadHit)
  );

  kwd_srs_detect #(.SRS_WIN(SRS_WIN)) u_srs (
    .clk  (clk),
    .rstN (rstN),
    .lowWr(lowWr),
    .swHit(swHit)
  );

  always_comb begin
    strobe.load        = enableRise || reloadHit;
    strobe.loadVal     = enableRise ? busWdata[WT_LSB +: WT_W] : wtQ;
    strobe.run         = wdeQ && !(wdzQ && lowPower);
    strobe.modeNoReset = wreQ;
    strobe.swReq       = swHit;
  end

  always_comb begin
    ctrlImage = '0;
    ctrlImage[WT_LSB +: WT_W] = wtQ;
    ctrlImage[BIT_SWRN] = srsNQ;
    ctrlImage[BIT_MODE] = wreQ;
    ctrlImage[BIT_EN]   = wdeQ;
    ctrlImage[BIT_SUSP] = wdzQ;
    statImage = '0;
    statImage[ST_W-1:0] = status;
    busRdata = '0;
    if (isRead) begin
      if (hitCtrl)      busRdata = ctrlImage;
      else if (hitStat) busRdata = statImage;
    end
  end
endmodule

// File: rtl/kwd_datapath.sv
`timescale 1ns/1ps
module kwd_datapath
  import kwd_pkg::*;
#(
  parameter int STEP_CYCLES = 16384
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            porN,
  input  strobe_t         strobe,
  output logic            sysRstReq,
  output logic            expiryPulse,
  output logic [ST_W-1:0] status
);
  localparam int PRE_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(STEP_CYCLES - 1);

  logic [PRE_W-1:0] pre;
  logic [WT_W-1:0]  cnt;
  logic             reqQ;
  logic             pulseQ;
  logic [ST_W-1:0]  statusQ;

  logic live, stepDone, expHit, expReset, newReq;

  assign live     = strobe.run && !reqQ;
  assign stepDone = (pre == PRE_LAST);
  assign expHit   = live && stepDone && (cnt == '0) && !strobe.load;
  assign expReset = expHit && !strobe.modeNoReset;
  assign newReq   = expReset || strobe.swReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pre <= '0;
      cnt <= '0;
    end else if (strobe.load) begin
      pre <= '0;
      cnt <= strobe.loadVal;
    end else if (live) begin
      if (stepDone) begin
        pre <= '0;
        if (cnt == '0) begin
          if (strobe.modeNoReset) cnt <= strobe.loadVal;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ   <= 1'b0;
      pulseQ <= 1'b0;
    end else begin
      reqQ   <= reqQ || newReq;
      pulseQ <= expHit && strobe.modeNoReset;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      statusQ <= '0;
    end else if (newReq && !reqQ) begin
      statusQ[ST_EXP] <= expReset;
      statusQ[ST_SW]  <= strobe.swReq;
    end
  end

  assign sysRstReq   = reqQ;
  assign expiryPulse = pulseQ;
  assign status      = statusQ;
endmodule

// File: rtl/keyed_watchdog.sv
`timescale 1ns/1ps
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int STEP_CYCLES = 16384,
  parameter int SRS_WIN     = 2
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       busWdata,
  output logic [15:0]       busRdata,
  input  logic              lowPower,
  output logic              sysRstReq,
  output logic              expiryPulse
);
  logic            coreRstN;
  strobe_t         strobe;
  logic [ST_W-1:0] statusQ;
  logic            wdeQ, wdzQ, wdzLockQ;

  assign coreRstN = rstN & porN;

  kwd_ctrl #(.ADDR_W(ADDR_W), .SRS_WIN(SRS_WIN)) u_ctrl (
    .clk     (clk),
    .rstN    (coreRstN),
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .lowPower(lowPower),
    .status  (statusQ),
    .strobe  (strobe),
    .wdeQ    (wdeQ),
    .wdzQ    (wdzQ),
    .wdzLockQ(wdzLockQ)
  );

  kwd_datapath #(.STEP_CYCLES(STEP_CYCLES)) u_dp (
    .clk        (clk),
    .rstN       (coreRstN),
    .porN       (porN),
    .strobe     (strobe),
    .sysRstReq  (sysRstReq),
    .expiryPulse(expiryPulse),
    .status     (statusQ)
  );
endmodule

// File: rtl/kwd_checker.sv
`timescale 1ns/1ps
module kwd_checker (
  input logic       clk,
  input logic       porN,
  input logic       rstN,
  input logic       sysRstReq,
  input logic       expiryPulse,
  input logic       wde,
  input logic       wdz,
  input logic       wdzLock,
  input logic [1:0] status
);
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    sysRstReq |=> sysRstReq);

  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    expiryPulse |=> !expiryPulse);

  p_enable_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    wde |=> wde);

  p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    !wde |=> !expiryPulse);

  p_suspend_locked_r4: assert property (@(posedge clk) disable iff (!rstN)
    wdzLock |=> ($stable(wdz) && wdzLock));

  p_cause_kept_r7: assert property (@(posedge clk) disable iff (!porN)
    sysRstReq |=> $stable(status));
endmodule

bind keyed_watchdog kwd_checker u_chk (
  .clk        (clk),
  .porN       (porN),
  .rstN       (coreRstN),
  .sysRstReq  (sysRstReq),
  .expiryPulse(expiryPulse),
  .wde        (wdeQ),
  .wdz        (wdzQ),
  .wdzLock    (wdzLockQ),
  .status     (statusQ)
);

// File: tb/sim_keyed_watchdog.sv
`timescale 1ns/1ps
module sim_keyed_watchdog;
  localparam int STEP = 4;
  localparam int WIN  = 2;

  logic        clk = 1'b0;
  logic        porN = 1'b0, rstN = 1'b0;
  logic        bSel = 1'b0, bWr = 1'b0;
  logic [2:0]  bAddr = '0;
  logic [15:0] bWdata = '0;
  logic        lowPower = 1'b0;
  logic [15:0] busRdata;
  logic        sysRstReq, expiryPulse;

  int total = 0;
  int bad = 0;
  int wdCyc = 0;

  always #10 clk = ~clk;

  keyed_watchdog #(.ADDR_W(3), .STEP_CYCLES(STEP), .SRS_WIN(WIN)) u0 (
    .clk(clk), .porN(porN), .rstN(rstN), .busSel(bSel), .busWr(bWr),
    .busAddr(bAddr), .busWdata(bWdata), .busRdata(busRdata),
    .lowPower(lowPower), .sysRstReq(sysRstReq), .expiryPulse(expiryPulse)
  );

  // ---------------- behavioural reference model ----------------
  int mWt, mWre, mWde, mWdz, mLock, mSrsN, mStatus;
  int mRemain, mReq, mPulse, mKey, mArmAt, mCyc;

  task automatic modelClear(input bit full);
    mWt = 0; mWre = 0; mWde = 0; mWdz = 0; mLock = 0; mSrsN = 1;
    mRemain = 0; mReq = 0; mPulse = 0; mKey = 0; mArmAt = -1;
    if (full) mStatus = 0;
  endtask

  initial modelClear(1'b1);

  always @(posedge clk) begin
    mCyc++;
    if (!porN) modelClear(1'b1);
    else if (!rstN) modelClear(1'b0);
    else begin
      bit ctrlW, svcW, running, sw, expd, pulse;
      ctrlW = bSel && bWr && bAddr == 3'd0;
      svcW  = bSel && bWr && bAddr == 3'd2;
      running = (mWde != 0) && !((mWdz != 0) && lowPower) && (mReq == 0);
      sw = 0; expd = 0; pulse = 0;
      if (ctrlW && !bWdata[4]) begin
        if (mArmAt >= 0 && (mCyc - mArmAt) <= WIN) begin sw = 1; mArmAt = -1; end
        else mArmAt = mCyc;
      end
      if (ctrlW && bWdata[2] && mWde == 0)
        mRemain = (int'(bWdata[15:8]) + 1) * STEP;
      else if (svcW && mKey != 0 && bWdata == 16'hAAAA)
        mRemain = (mWt + 1) * STEP;
      else if (running) begin
        mRemain--;
        if (mRemain == 0) begin
          expd = 1;
          if (mWre != 0) begin pulse = 1; mRemain = (mWt + 1) * STEP; end
        end
      end
      if (((expd && mWre == 0) || sw) && mReq == 0) begin
        mStatus = ((expd && mWre == 0) ? 2 : 0) + (sw ? 1 : 0);
        mReq = 1;
      end
      mPulse = pulse;
      if (svcW) mKey = (bWdata == 16'h5555) ? 1 : 0;
      if (ctrlW) begin
        mWt = int'(bWdata[15:8]); mWre = bWdata[3]; mSrsN = bWdata[4];
        if (bWdata[2]) mWde = 1;
        if (mLock == 0) begin mWdz = bWdata[0]; mLock = 1; end
      end
    end
  end

  function automatic logic [15:0] expRead();
    logic [15:0] v;
    v = '0;
    if (bSel && !bWr) begin
      if (bAddr == 3'd0)
        v = {mWt[7:0], 3'b000, mSrsN[0], mWre[0], mWde[0], 1'b0, mWdz[0]};
      else if (bAddr == 3'd4)
        v = {14'd0, mStatus[1:0]};
    end
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (porN && rstN) begin
      chk(busRdata == expRead(), "R11 read data", busRdata, expRead());
      chk(sysRstReq == mReq[0], "R5 reset request", sysRstReq, mReq);
      chk(expiryPulse == mPulse[0], "R5 expiry pulse", expiryPulse, mPulse);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #5; end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [15:0] d);
    bSel = 1; bWr = 1; bAddr = a; bWdata = d;
    @(posedge clk); #5;
    bSel = 0; bWr = 0; bAddr = '0; bWdata = '0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [15:0] d);
    bSel = 1; bWr = 0; bAddr = a;
    #3 d = busRdata;
    @(posedge clk); #5;
    bSel = 0; bAddr = '0;
  endtask

  task automatic sysReset();
    rstN = 0; tick(2); rstN = 1;
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    wdCyc++;
    if (wdCyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog expired (R1 run incomplete) act=%0d exp=0", wdCyc);
      finishRun();
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    logic [15:0] rd;
    tick(3);
    porN = 1; rstN = 1;

    // R1: reset state
    busRead(3'd0, rd); chk(rd == 16'h0010, "R1 control reset", rd, 16'h0010);
    busRead(3'd4, rd); chk(rd == 16'h0000, "R1 cause reset", rd, 0);
    chk(!sysRstReq && !expiryPulse, "R1 outputs low", sysRstReq, 0);

    // R2/R10: W=2 loaded by enabling write, expiry 12 edges later
    busWrite(3'd0, 16'h0214);
    tick(11); chk(sysRstReq == 0, "R10 no early expiry", sysRstReq, 0);
    tick(1);  chk(sysRstReq == 1, "R2 expiry at (W+1)*STEP", sysRstReq, 1);
    busRead(3'd4, rd); chk(rd == 16'h0002, "R7 timeout cause", rd, 2);
    busWrite(3'd4, 16'hFFFF);
    busRead(3'd4, rd); chk(rd == 16'h0002, "R7 write ignored", rd, 2);
    sysReset();
    busRead(3'd0, rd); chk(rd == 16'h0010, "R3 enable cleared by reset", rd, 16'h0010);
    busRead(3'd4, rd); chk(rd == 16'h0002, "R7 survives rstN", rd, 2);
    chk(sysRstReq == 0, "R5 request dropped by reset", sysRstReq, 0);

    // R3/R8: sticky enable, new W used only at reload
    busWrite(3'd0, 16'h0514);
    busWrite(3'd0, 16'h0010);
    busRead(3'd0, rd); chk(rd == 16'h0014, "R3 enable sticky", rd, 16'h0014);
    busWrite(3'd2, 16'h5555);
    busWrite(3'd2, 16'hAAAA);
    tick(3); chk(sysRstReq == 0, "R8 reload uses new W", sysRstReq, 0);
    tick(1); chk(sysRstReq == 1, "R8 expiry from new W", sysRstReq, 1);
    sysReset();

    // R6: cancelled key sequence does not reload
    busWrite(3'd0, 16'h0114);
    busWrite(3'd2, 16'h5555);
    busWrite(3'd2, 16'h1234);
    busWrite(3'd2, 16'hAAAA);
    tick(4); chk(sysRstReq == 0, "R6 before expiry", sysRstReq, 0);
    tick(1); chk(sysRstReq == 1, "R6 cancelled key no reload", sysRstReq, 1);
    sysReset();

    // R5: pulse mode, then R6: completed key delays next pulse
    busWrite(3'd0, 16'h011C);
    tick(7); chk(expiryPulse == 0, "R5 no early pulse", expiryPulse, 0);
    tick(1); chk(expiryPulse == 1, "R5 pulse on expiry", expiryPulse, 1);
    tick(1); chk(expiryPulse == 0 && sysRstReq == 0, "R5 single pulse, no request", expiryPulse, 0);
    busWrite(3'd2, 16'h5555);
    busWrite(3'd2, 16'h5555);
    busWrite(3'd2, 16'hAAAA);
    tick(5); chk(expiryPulse == 0, "R6 reload postponed pulse", expiryPulse, 0);
    tick(3); chk(expiryPulse == 1, "R6 pulse after reload", expiryPulse, 1);
    sysReset();

    // R4: suspend write-once and pause under low power
    lowPower = 1;
    busWrite(3'd0, 16'h0011);
    busWrite(3'd0, 16'h0010);
    busRead(3'd0, rd); chk(rd == 16'h0011, "R4 suspend write-once", rd, 16'h0011);
    busWrite(3'd0, 16'h0014);
    tick(9); chk(sysRstReq == 0, "R4 paused in low power", sysRstReq, 0);
    lowPower = 0;
    tick(3); chk(sysRstReq == 0, "R4 resumed count", sysRstReq, 0);
    tick(1); chk(sysRstReq == 1, "R4 expiry after resume", sysRstReq, 1);
    sysReset();
    busWrite(3'd0, 16'h0010);
    busRead(3'd0, rd); chk(rd == 16'h0010, "R4 lock cleared by reset", rd, 16'h0010);

    // R9: software reset window
    busWrite(3'd0, 16'h0000);
    tick(5); chk(sysRstReq == 0, "R9 single write no request", sysRstReq, 0);
    busWrite(3'd0, 16'h0000);
    tick(2);
    busWrite(3'd0, 16'h0000);
    chk(sysRstReq == 0, "R9 gap too wide", sysRstReq, 0);
    tick(5);
    busWrite(3'd0, 16'h0000);
    tick(1);
    busWrite(3'd0, 16'h0000);
    chk(sysRstReq == 1, "R9 two writes in window", sysRstReq, 1);
    busRead(3'd4, rd); chk(rd == 16'h0001, "R9 software cause", rd, 1);
    sysReset();

    // R11: service offset reads zero
    busRead(3'd2, rd); chk(rd == 16'h0000, "R11 service reads zero", rd, 0);

    // R7: power-on clears cause
    porN = 0; rstN = 0; tick(2); porN = 1; rstN = 1;
    busRead(3'd4, rd); chk(rd == 16'h0000, "R7 cleared by power-on", rd, 0);
    busRead(3'd0, rd); chk(rd == 16'h0010, "R1 control after power-on", rd, 16'h0010);

    tick(2);
    finishRun();
  end
endmodule